// File: doc/BRIEF.md
# Bus Slave Cycle Decoder and Router

This block sits behind the slave side of a parallel backplane bus. For each incoming cycle it decides whether the board answers and which local agent serves the cycle. There are three agents: the register file, the on-board memory and the bridge master. The bridge master carries the cycle on to a downstream bus.

Three address decoders classify a cycle:
- A fixed logical-address region in the 16-bit space goes to the register file.
- A wide region in the 24-bit or 32-bit space goes to the register file or to memory. The offset inside the region decides which.
- A set of equally sized extender windows sends the cycle to the bridge master.

When decoders overlap, a fixed priority picks one result.

The block also checks that the transfer width, cycle kind and address space form an accepted combination. An unaligned request is folded to a 32-bit transfer before that check. Accepted cycles are handed to the chosen agent with a level request. The acknowledge, or the error the agent returns, goes back to the bus and is held until the master withdraws its strobe.

Top module: `slave_cycle_router`

## Requirements
- R1: A cycle in the 16-bit space (space code 0) whose address bits [15:6] equal those of 0xC000 is routed to the register file (`reg_req`). Address bits above bit 15 are ignored in that space.
- R2: A cycle in the 24-bit space (code 1) inside 0x200000–0x2FFFFF, or in the 32-bit space (code 2) inside 0x40000000–0x40FFFFFF, goes to the register file when its offset in the region is below 0x1000, and to memory (`mem_req`) otherwise. In the 24-bit space only address bits [23:0] count.
- R3: A cycle in any valid space whose trimmed address lies in 0xC000–0xFFFF or 0x200000–0x203FFF hits an extender window and is routed to the bridge master (`fwd_req`).
- R4: On overlap, the logical-address decoder wins over the wide decoder, and the wide decoder wins over the extender windows.
- R5: A cycle that hits no decoder, including any cycle with space code 3, raises no target request, no acknowledge and no error. The block then waits for the strobe to drop.
- R6: Single (kind 0) and read-modify-write (kind 1) cycles of width 8 (code 0), 16 (code 1) or 32 bits (code 2) are accepted in all three spaces.
- R7: A 64-bit (width code 3) or block (kind 2) cycle that hits a decoder in the 16-bit space is answered with `bus_berr` and no target request. So is any hitting cycle of kind 3. A 64-bit block cycle in the 24-bit or 32-bit space is accepted.
- R8: When `bus_unaligned` is set, the cycle is judged and forwarded as a 32-bit transfer (`tgt_width` = 2), whatever its width code.
- R9: The target request is raised one cycle after the strobe is sampled and is held until that target's done. Done from any other target is ignored. `bus_ack` rises the cycle after done without error. `bus_berr` rises instead when the target reports an error. `tgt_addr` carries the trimmed address.
- R10: `bus_ack` and `bus_berr` stay high while `bus_req` stays high. Both clear one cycle after the strobe drops, and a new cycle can then start.
- R11: The error for an unaccepted combination appears one cycle after the strobe is sampled.
- R12: After reset, no request, acknowledge or error is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Cycle strobe, held until answered |
| bus_addr | input | 32 | Cycle address |
| bus_space | input | 2 | 0 = 16-bit, 1 = 24-bit, 2 = 32-bit, 3 = none |
| bus_width | input | 2 | 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| bus_kind | input | 2 | 0 = single, 1 = read-modify-write, 2 = block, 3 = reserved |
| bus_unaligned | input | 1 | Request is unaligned |
| bus_ack | output | 1 | Acknowledge to the bus |
| bus_berr | output | 1 | Bus error to the bus |
| reg_req | output | 1 | Request to the register file |
| mem_req | output | 1 | Request to memory |
| fwd_req | output | 1 | Request to the bridge master |
| tgt_addr | output | 32 | Trimmed address for the target |
| tgt_space | output | 2 | Space code for the target |
| tgt_width | output | 2 | Effective width code for the target |
| tgt_kind | output | 2 | Cycle kind for the target |
| reg_done | input | 1 | Register file finished |
| reg_err | input | 1 | Register file error, valid with done |
| mem_done | input | 1 | Memory finished |
| mem_err | input | 1 | Memory error, valid with done |
| fwd_done | input | 1 | Bridge master finished |
| fwd_err | input | 1 | Bridge master error, valid with done |

## Verification
Each result has a fixed due cycle:
- A target request is due one rising edge after the strobe is first sampled. An error for an unaccepted combination is due on the same edge.
- The acknowledge or error is due one edge after the selected done is sampled.
- Both clear one edge after the strobe is seen low.

The bench keeps a behavioural model that advances on the same rising edge as the design. At every falling edge it compares all outputs against the model, so each result is checked in exactly the cycle it is due. The scenarios sweep decoder boundaries, overlaps, rejected combinations, unaligned folding, stray done pulses and target errors.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
// Shared codes for the slave cycle router.
// Assumes the encodings listed in the brief; all modules import this package.
package sbr_pkg;
    typedef enum logic [1:0] {SP_A16 = 2'd0, SP_A24 = 2'd1, SP_A32 = 2'd2, SP_NONE = 2'd3} space_e;
    typedef enum logic [1:0] {W_D8 = 2'd0, W_D16 = 2'd1, W_D32 = 2'd2, W_D64 = 2'd3} width_e;
    typedef enum logic [1:0] {K_SINGLE = 2'd0, K_RMW = 2'd1, K_BLOCK = 2'd2, K_RSVD = 2'd3} kind_e;
    typedef enum logic [1:0] {ROUTE_REG = 2'd0, ROUTE_MEM = 2'd1, ROUTE_FWD = 2'd2, ROUTE_NONE = 2'd3} route_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_HOLD = 2'd2} state_e;
    localparam int NUM_TGT = 3;
endpackage

// File: rtl/sbr_decode.sv
`timescale 1ns/1ps
// Address classification for the slave cycle router.
// Trims the address to the width of its space, runs the logical-address,
// wide (24/32-bit) and extender-window decoders, and resolves overlaps with
// the priority logical > wide > window. Purely combinational; clk and rst_n
// only clock the checks. Assumes all windows share one power-of-two size and
// every base is aligned to its region size.
module sbr_decode
    import sbr_pkg::*;
#(
    parameter logic [15:0] LA_BASE   = 16'hC000,
    parameter int          LA_LOG2   = 6,
    parameter logic [23:0] A24_BASE  = 24'h20_0000,
    parameter int          A24_LOG2  = 20,
    parameter logic [31:0] A32_BASE  = 32'h4000_0000,
    parameter int          A32_LOG2  = 24,
    parameter int          REG_LOG2  = 12,
    parameter int          NUM_WIN   = 2,
    parameter int          WIN_LOG2  = 14,
    parameter logic [NUM_WIN*32-1:0] WIN_BASE = {32'h0020_0000, 32'h0000_C000}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  space_e      space,
    input  logic [31:0] addr,
    output route_e      route,
    output logic [31:0] addr_trim
);
    logic               la_hit;
    logic               wide_hit;
    logic               wide_reg;
    logic [NUM_WIN-1:0] win_hit;

    // Drop address bits the current space does not carry.
    always_comb begin
        case (space)
            SP_A16:  addr_trim = {16'h0, addr[15:0]};
            SP_A24:  addr_trim = {8'h0, addr[23:0]};
            default: addr_trim = addr;
        endcase
    end

    // Logical-address region lives only in the 16-bit space.
    assign la_hit = (space == SP_A16) && (addr_trim[15:LA_LOG2] == LA_BASE[15:LA_LOG2]);

    // Wide region: hit test and register/memory split by offset.
    always_comb begin
        wide_hit = 1'b0;
        wide_reg = 1'b0;
        if (space == SP_A24) begin
            wide_hit = (addr_trim[23:A24_LOG2] == A24_BASE[23:A24_LOG2]);
            wide_reg = (addr_trim[A24_LOG2-1:REG_LOG2] == '0);
        end else if (space == SP_A32) begin
            wide_hit = (addr_trim[31:A32_LOG2] == A32_BASE[31:A32_LOG2]);
            wide_reg = (addr_trim[A32_LOG2-1:REG_LOG2] == '0);
        end
    end

    // One comparator per extender window.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [31:0] WB = WIN_BASE[g*32 +: 32];
        assign win_hit[g] = (space != SP_NONE) && (addr_trim[31:WIN_LOG2] == WB[31:WIN_LOG2]);
    end

    // Fixed priority between the three decoder classes.
    always_comb begin
        if (la_hit)        route = ROUTE_REG;
        else if (wide_hit) route = wide_reg ? ROUTE_REG : ROUTE_MEM;
        else if (|win_hit) route = ROUTE_FWD;
        else               route = ROUTE_NONE;
    end

    // R4: a window overlapping the logical region never steals the cycle
    a_r4_la_over_window: assert property (@(posedge clk) disable iff (!rst_n)
        (la_hit && (|win_hit)) |-> (route == ROUTE_REG));
    // R4: a window overlapping the wide region never steals the cycle
    a_r4_wide_over_window: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_hit && (|win_hit)) |-> (route != ROUTE_FWD));
    // R5: the reserved space code matches nothing
    a_r5_no_space_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (space == SP_NONE) |-> (route == ROUTE_NONE));
endmodule

// File: rtl/sbr_accept.sv
`timescale 1ns/1ps
// Acceptance rules for the slave cycle router.
// Folds unaligned requests to 32 bits, then rejects 64-bit or block cycles
// in the 16-bit space and the reserved cycle kind. Combinational.
// Assumes it is only consulted for cycles that hit a decoder.
module sbr_accept
    import sbr_pkg::*;
(
    input  space_e space,
    input  width_e width,
    input  kind_e  kind,
    input  logic   unaligned,
    output width_e eff_width,
    output logic   ok
);
    logic wide_only;

    // Unaligned transfers are handled as 32-bit ones.
    assign eff_width = unaligned ? W_D32 : width;

    // 64-bit and block transfers need a 24-bit or 32-bit space.
    assign wide_only = (eff_width == W_D64) || (kind == K_BLOCK);

    // Final verdict on the combination.
    assign ok = (kind != K_RSVD) && !(wide_only && (space == SP_A16));
endmodule

// File: rtl/sbr_seq.sv
`timescale 1ns/1ps
// Cycle sequencer for the slave cycle router.
// Samples a new cycle in IDLE. It either ignores the cycle (no hit), errors
// it (rejected), or holds a one-hot request to the chosen target until that
// target's done. The response is then held until the strobe drops.
// Assumes the master keeps bus_req and the cycle fields steady until answered.
module sbr_seq
    import sbr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  route_e             route,
    input  logic               ok,
    input  logic [31:0]        addr_trim,
    input  space_e             space,
    input  width_e             eff_width,
    input  kind_e              kind,
    input  logic [NUM_TGT-1:0] tgt_done,
    input  logic [NUM_TGT-1:0] tgt_err,
    output logic [NUM_TGT-1:0] tgt_req,
    output logic [31:0]        tgt_addr,
    output space_e             tgt_space,
    output width_e             tgt_width,
    output kind_e              tgt_kind,
    output logic               bus_ack,
    output logic               bus_berr
);
    state_e           st;
    route_e           route_q;
    logic [NUM_TGT:0] done_pad;
    logic [NUM_TGT:0] err_pad;
    logic             sel_done;
    logic             sel_err;

    // Pick done/error from the selected target only.
    assign done_pad = {1'b0, tgt_done};
    assign err_pad  = {1'b0, tgt_err};
    assign sel_done = done_pad[route_q];
    assign sel_err  = err_pad[route_q];

    // Main sequencer: accept, dispatch, respond, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            route_q   <= ROUTE_NONE;
            bus_ack   <= 1'b0;
            bus_berr  <= 1'b0;
            tgt_addr  <= '0;
            tgt_space <= SP_A16;
            tgt_width <= W_D8;
            tgt_kind  <= K_SINGLE;
        end else begin
            case (st)
                ST_IDLE: if (bus_req) begin
                    tgt_addr  <= addr_trim;
                    tgt_space <= space;
                    tgt_width <= eff_width;
                    tgt_kind  <= kind;
                    if (route == ROUTE_NONE) begin
                        st <= ST_HOLD;
                    end else if (!ok) begin
                        bus_berr <= 1'b1;
                        st       <= ST_HOLD;
                    end else begin
                        route_q <= route;
                        st      <= ST_BUSY;
                    end
                end
                ST_BUSY: if (sel_done) begin
                    bus_ack  <= !sel_err;
                    bus_berr <= sel_err;
                    route_q  <= ROUTE_NONE;
                    st       <= ST_HOLD;
                end
                ST_HOLD: if (!bus_req) begin
                    bus_ack  <= 1'b0;
                    bus_berr <= 1'b0;
                    st       <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // One request line per target, live only while dispatched.
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_req
        assign tgt_req[g] = (st == ST_BUSY) && (route_q == route_e'(g));
    end

    // R9: at most one target is requested at a time
    a_r9_onehot_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_req));
    // R9: acknowledge only follows a done from the selected target
    a_r9_ack_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> $past(sel_done && (|tgt_req)));
    // R10: response held while the strobe stays high
    a_r10_hold_resp: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_ack || bus_berr) && bus_req) |=> (bus_ack || bus_berr));
    // R10: response released after the strobe drops
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HOLD) && !bus_req) |=> (!bus_ack && !bus_berr));
    // R5: a miss gets no answer and no request
    a_r5_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && bus_req && (route == ROUTE_NONE)) |=> (!bus_ack && !bus_berr && (tgt_req == '0)));
    // R11: a rejected combination errors on the next cycle without a request
    a_r11_reject_err: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && bus_req && (route != ROUTE_NONE) && !ok) |=> (bus_berr && (tgt_req == '0)));
    // R5: acknowledge and error never together
    a_r5_ack_berr_mutex: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_berr));
endmodule

// File: rtl/slave_cycle_router.sv
`timescale 1ns/1ps
// Top of the slave cycle router.
// Ties the decoders, the acceptance rules and the sequencer together and maps
// the plain port codes onto the package types. Assumes a synchronous
// active-low reset and a master that holds each cycle until it is answered.
module slave_cycle_router
    import sbr_pkg::*;
#(
    parameter logic [15:0] LA_BASE  = 16'hC000,
    parameter int          LA_LOG2  = 6,
    parameter logic [23:0] A24_BASE = 24'h20_0000,
    parameter int          A24_LOG2 = 20,
    parameter logic [31:0] A32_BASE = 32'h4000_0000,
    parameter int          A32_LOG2 = 24,
    parameter int          REG_LOG2 = 12,
    parameter int          NUM_WIN  = 2,
    parameter int          WIN_LOG2 = 14,
    parameter logic [NUM_WIN*32-1:0] WIN_BASE = {32'h0020_0000, 32'h0000_C000}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic [31:0] bus_addr,
    input  logic [1:0]  bus_space,
    input  logic [1:0]  bus_width,
    input  logic [1:0]  bus_kind,
    input  logic        bus_unaligned,
    output logic        bus_ack,
    output logic        bus_berr,
    output logic        reg_req,
    output logic        mem_req,
    output logic        fwd_req,
    output logic [31:0] tgt_addr,
    output logic [1:0]  tgt_space,
    output logic [1:0]  tgt_width,
    output logic [1:0]  tgt_kind,
    input  logic        reg_done,
    input  logic        reg_err,
    input  logic        mem_done,
    input  logic        mem_err,
    input  logic        fwd_done,
    input  logic        fwd_err
);
    space_e             space;
    width_e             width;
    kind_e              kind;
    route_e             route;
    width_e             eff_width;
    logic               ok;
    logic [31:0]        addr_trim;
    logic [NUM_TGT-1:0] req_vec;
    space_e             tgt_space_e;
    width_e             tgt_width_e;
    kind_e              tgt_kind_e;

    // Port codes onto package types.
    assign space = space_e'(bus_space);
    assign width = width_e'(bus_width);
    assign kind  = kind_e'(bus_kind);

    sbr_decode #(
        .LA_BASE(LA_BASE), .LA_LOG2(LA_LOG2),
        .A24_BASE(A24_BASE), .A24_LOG2(A24_LOG2),
        .A32_BASE(A32_BASE), .A32_LOG2(A32_LOG2),
        .REG_LOG2(REG_LOG2), .NUM_WIN(NUM_WIN),
        .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .space(space), .addr(bus_addr),
        .route(route), .addr_trim(addr_trim)
    );

    sbr_accept u_accept (
        .space(space), .width(width), .kind(kind), .unaligned(bus_unaligned),
        .eff_width(eff_width), .ok(ok)
    );

    sbr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req),
        .route(route), .ok(ok), .addr_trim(addr_trim),
        .space(space), .eff_width(eff_width), .kind(kind),
        .tgt_done({fwd_done, mem_done, reg_done}),
        .tgt_err({fwd_err, mem_err, reg_err}),
        .tgt_req(req_vec), .tgt_addr(tgt_addr),
        .tgt_space(tgt_space_e), .tgt_width(tgt_width_e), .tgt_kind(tgt_kind_e),
        .bus_ack(bus_ack), .bus_berr(bus_berr)
    );

    // Request lines and target fields back onto plain ports.
    assign reg_req   = req_vec[ROUTE_REG];
    assign mem_req   = req_vec[ROUTE_MEM];
    assign fwd_req   = req_vec[ROUTE_FWD];
    assign tgt_space = tgt_space_e;
    assign tgt_width = tgt_width_e;
    assign tgt_kind  = tgt_kind_e;
endmodule

// File: tb/slave_cycle_router_test.sv
`timescale 1ns/1ps
module slave_cycle_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_space = '0, bus_width = '0, bus_kind = '0;
    logic        bus_unaligned = 1'b0;
    logic        bus_ack, bus_berr, reg_req, mem_req, fwd_req;
    logic [31:0] tgt_addr;
    logic [1:0]  tgt_space, tgt_width, tgt_kind;
    logic        reg_done = 0, reg_err = 0, mem_done = 0, mem_err = 0, fwd_done = 0, fwd_err = 0;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    checking = 0;
    bit    finished = 0;
    string cur_tag = "R12";

    // behavioural reference state
    int          m_st = 0;      // 0 idle, 1 dispatched, 2 answered/holding
    int          m_tgt = 0;     // 0 reg, 1 mem, 2 fwd
    bit          m_ack = 0, m_berr = 0;
    logic [31:0] m_addr = '0;
    int          m_w = 0, m_sp = 0, m_kd = 0;

    always #2 clk = ~clk;

    slave_cycle_router uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_space(bus_space), .bus_width(bus_width), .bus_kind(bus_kind),
        .bus_unaligned(bus_unaligned), .bus_ack(bus_ack), .bus_berr(bus_berr),
        .reg_req(reg_req), .mem_req(mem_req), .fwd_req(fwd_req),
        .tgt_addr(tgt_addr), .tgt_space(tgt_space), .tgt_width(tgt_width), .tgt_kind(tgt_kind),
        .reg_done(reg_done), .reg_err(reg_err), .mem_done(mem_done), .mem_err(mem_err),
        .fwd_done(fwd_done), .fwd_err(fwd_err)
    );

    function automatic logic [31:0] trim(input logic [1:0] sp, input logic [31:0] a);
        if (sp == 2'd0) return a & 32'h0000_FFFF;
        if (sp == 2'd1) return a & 32'h00FF_FFFF;
        return a;
    endfunction

    // -1 none, 0 register file, 1 memory, 2 bridge master
    function automatic int ref_route(input logic [1:0] sp, input logic [31:0] a);
        logic [31:0] t;
        if (sp == 2'd3) return -1;
        t = trim(sp, a);
        if (sp == 2'd0 && t >= 32'hC000 && t < 32'hC040) return 0;
        if (sp == 2'd1 && t >= 32'h20_0000 && t < 32'h30_0000) return (t - 32'h20_0000 < 32'h1000) ? 0 : 1;
        if (sp == 2'd2 && t >= 32'h4000_0000 && t < 32'h4100_0000) return (t - 32'h4000_0000 < 32'h1000) ? 0 : 1;
        if ((t >= 32'hC000 && t < 32'h1_0000) || (t >= 32'h20_0000 && t < 32'h20_4000)) return 2;
        return -1;
    endfunction

    function automatic bit ref_ok(input int sp, input int w, input int kd);
        if (kd == 3) return 0;
        if ((w == 3 || kd == 2) && sp == 0) return 0;
        return 1;
    endfunction

    // Advance the reference on the same edge as the design.
    always @(posedge clk) begin
        int r;
        bit d, e;
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_ack = 0; m_berr = 0;
        end else begin
            case (m_st)
                0: if (bus_req) begin
                    r      = ref_route(bus_space, bus_addr);
                    m_addr = trim(bus_space, bus_addr);
                    m_w    = bus_unaligned ? 2 : int'(bus_width);
                    m_sp   = int'(bus_space);
                    m_kd   = int'(bus_kind);
                    if (r < 0) m_st = 2;
                    else if (!ref_ok(m_sp, m_w, m_kd)) begin m_berr = 1; m_st = 2; end
                    else begin m_tgt = r; m_st = 1; end
                end
                1: begin
                    d = (m_tgt == 0) ? reg_done : (m_tgt == 1) ? mem_done : fwd_done;
                    e = (m_tgt == 0) ? reg_err  : (m_tgt == 1) ? mem_err  : fwd_err;
                    if (d) begin m_ack = !e; m_berr = e; m_st = 2; end
                end
                default: if (!bus_req) begin m_ack = 0; m_berr = 0; m_st = 0; end
            endcase
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_tag, what, act, exp);
        end
    endtask

    // Compare every output against the reference away from the active edge.
    always @(negedge clk) if (checking && !finished) begin
        chk("bus_ack", bus_ack, m_ack);
        chk("bus_berr", bus_berr, m_berr);
        chk("reg_req", reg_req, (m_st == 1 && m_tgt == 0));
        chk("mem_req", mem_req, (m_st == 1 && m_tgt == 1));
        chk("fwd_req", fwd_req, (m_st == 1 && m_tgt == 2));
        if (m_st == 1) begin
            chk("tgt_addr", tgt_addr, m_addr);
            chk("tgt_width", tgt_width, m_w);
            chk("tgt_space", tgt_space, m_sp);
            chk("tgt_kind", tgt_kind, m_kd);
        end
    end

    // Run one bus cycle; the bench plays the target that gets requested.
    task automatic run(input string tag, input logic [1:0] sp, input logic [31:0] a,
                       input logic [1:0] w, input logic [1:0] kd, input bit un,
                       input int dly, input bit err, input bit stray, input int hold);
        bit got;
        got = 0;
        @(negedge clk);
        cur_tag = tag;
        bus_space = sp; bus_addr = a; bus_width = w; bus_kind = kd; bus_unaligned = un;
        bus_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (reg_req || mem_req || fwd_req) begin got = 1; break; end
        end
        if (got) begin
            if (stray) begin
                if (reg_req) mem_done = 1; else reg_done = 1;
                @(negedge clk);
                mem_done = 0; reg_done = 0;
            end
            repeat (dly) @(negedge clk);
            if (reg_req) begin reg_done = 1; reg_err = err; end
            else if (mem_req) begin mem_done = 1; mem_err = err; end
            else if (fwd_req) begin fwd_done = 1; fwd_err = err; end
            @(negedge clk);
            reg_done = 0; reg_err = 0; mem_done = 0; mem_err = 0; fwd_done = 0; fwd_err = 0;
        end
        repeat (hold) @(negedge clk);
        bus_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) if (cyc > 50000 && !finished) begin
        finished = 1;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(posedge clk);
        checking = 1;
        cur_tag = "R12";              // R12 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 logical-address decoder, upper bits ignored in the 16-bit space
        run("R1", 2'd0, 32'h0000_C010, 2'd1, 2'd0, 0, 0, 0, 0, 2);
        run("R1", 2'd0, 32'h1234_C03C, 2'd2, 2'd0, 0, 1, 0, 0, 1);
        // R2 wide decoder register/memory split and boundaries
        run("R2", 2'd1, 32'h0020_0FFF, 2'd2, 2'd0, 0, 0, 0, 0, 1);
        run("R2", 2'd1, 32'hAA20_1000, 2'd2, 2'd0, 0, 0, 0, 0, 1);
        run("R2", 2'd2, 32'h40AB_CDEC, 2'd2, 2'd0, 0, 2, 0, 0, 1);
        run("R2", 2'd2, 32'h4000_0004, 2'd1, 2'd0, 0, 0, 0, 0, 1);
        // R3 extender windows
        run("R3", 2'd0, 32'h0000_D000, 2'd1, 2'd0, 0, 0, 0, 0, 1);
        run("R3", 2'd2, 32'h0000_C100, 2'd2, 2'd0, 0, 0, 0, 0, 1);
        run("R3", 2'd2, 32'h0020_0010, 2'd2, 2'd2, 0, 0, 0, 0, 1);
        // R4 overlap priority
        run("R4", 2'd0, 32'h0000_C000, 2'd0, 2'd0, 0, 0, 0, 0, 1);
        run("R4", 2'd1, 32'h0020_0010, 2'd2, 2'd0, 0, 0, 0, 0, 1);
        run("R4", 2'd1, 32'h0020_2000, 2'd2, 2'd0, 0, 0, 0, 0, 1);
        // R5 misses: no answer while strobe is held
        run("R5", 2'd0, 32'h0000_1000, 2'd3, 2'd0, 0, 0, 0, 0, 4);
        run("R5", 2'd3, 32'h0000_C000, 2'd2, 2'd0, 0, 0, 0, 0, 3);
        run("R5", 2'd1, 32'h0010_0000, 2'd2, 2'd0, 0, 0, 0, 0, 2);
        // R6 accepted widths and kinds in every space
        run("R6", 2'd0, 32'h0000_C004, 2'd0, 2'd1, 0, 0, 0, 0, 1);
        run("R6", 2'd1, 32'h0025_0000, 2'd2, 2'd1, 0, 0, 0, 0, 1);
        run("R6", 2'd2, 32'h0000_F000, 2'd1, 2'd0, 0, 0, 0, 0, 1);
        // R7 and R11 rejected combinations, plus an accepted wide 64-bit block
        run("R7", 2'd0, 32'h0000_C008, 2'd3, 2'd0, 0, 0, 0, 0, 2);
        run("R11", 2'd0, 32'h0000_E000, 2'd1, 2'd2, 0, 0, 0, 0, 2);
        run("R7", 2'd1, 32'h0020_0020, 2'd2, 2'd3, 0, 0, 0, 0, 2);
        run("R7", 2'd1, 32'h0028_0000, 2'd3, 2'd2, 0, 0, 0, 0, 1);
        // R8 unaligned folds to 32-bit
        run("R8", 2'd0, 32'h0000_C00C, 2'd3, 2'd0, 1, 0, 0, 0, 1);
        run("R8", 2'd2, 32'h4020_0001, 2'd0, 2'd1, 1, 0, 0, 0, 1);
        // R9 target errors, long waits, stray done from other targets
        run("R9", 2'd0, 32'h0000_C020, 2'd2, 2'd0, 0, 0, 1, 0, 1);
        run("R9", 2'd2, 32'h0020_3FF0, 2'd2, 2'd0, 0, 5, 1, 1, 1);
        run("R9", 2'd1, 32'h002F_FFF0, 2'd2, 2'd0, 0, 3, 0, 1, 1);
        // R10 long hold of the response, then back-to-back cycles
        run("R10", 2'd2, 32'h4000_0010, 2'd2, 2'd0, 0, 0, 0, 0, 6);
        run("R10", 2'd2, 32'h4080_0010, 2'd2, 2'd0, 0, 0, 1, 0, 5);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule